// File: doc/BRIEF.md
# Two-Level Turn-Off Timing Controller

This block sequences the switching phases of an isolated power-transistor gate driver. When the gate command drops, it does not pull the gate straight to the negative rail. It first enables an intermediate clamp level for a programmed number of clock cycles, and only then enables the full pull-down. This limits the overvoltage that a fast collector-current collapse would cause. So that the plateau does not shorten the effective output pulse, the same delay is inserted before every turn-on. The interval between the drive starting and the full pull-down starting therefore equals the command's high time.

The plateau duration comes in as a digital cycle count, which stands in for an external timing capacitor. The count is capped at a hard limit. A strap input models a shorted timing node: it removes the plateau and the turn-on delay altogether. A 2-bit code selects one of three intermediate clamp levels and is passed on as a one-hot select during the plateau. Generating the analog clamp voltage and its slope is outside this block.

Top module: `tlto_ctrl`

## Requirements
- R1: In reset and after reset `full_off` is 1 and `drv_on`, `mid_en` are 0. At every cycle exactly one of `drv_on`, `mid_en`, `full_off` is 1.
- R2: The effective delay D is 0 while `strap_off` is 1. Otherwise D is `plat_cycles`, limited to LIMIT_CYC. D is taken at the clock edge that starts a turn-on wait or a plateau.
- R3: `drv_on` rises D clock edges after the first edge that samples `cmd_on` high, or at that edge when D is 0. If `cmd_on` is sampled low during the wait, the wait is cancelled and `drv_on` stays low.
- R4: At the edge that samples `cmd_on` low while `drv_on` is 1, `mid_en` rises and stays high for exactly D cycles, after which `full_off` rises. When D is 0, `full_off` rises at that edge.
- R5: `mid_en` is never high for more than LIMIT_CYC consecutive cycles. A programmed count above LIMIT_CYC gives a plateau of exactly LIMIT_CYC cycles.
- R6: With no abort, the number of cycles from `drv_on` rising to `full_off` rising equals the number of edges that sampled `cmd_on` high.
- R7: While `strap_off` is 1, `mid_en` never rises, `drv_on` rises at the first edge sampling `cmd_on` high, and `full_off` rises at the first edge sampling it low.
- R8: If `cmd_on` is sampled high during a plateau, `mid_en` falls at that edge. The turn-on delay restarts from zero, so `drv_on` rises D edges later.
- R9: `mid_lvl` is one-hot while `mid_en` is 1 and zero otherwise. It reflects `lvl_code` taken at the plateau start: 00 gives bit 0 (lowest level), 01 gives bit 1, 10 gives bit 2 (highest level), and 11 gives bit 1 (the middle level).
- R10: Changes of `plat_cycles` or `lvl_code` after a wait or plateau has started do not change that wait or plateau.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_on | input | 1 | Gate command, 1 = conduct |
| plat_cycles | input | PLAT_W | Programmed plateau and turn-on delay, in cycles |
| strap_off | input | 1 | Timing node shorted: no plateau, no delay |
| lvl_code | input | 2 | Intermediate clamp level select |
| drv_on | output | 1 | Turn-on drive enable |
| mid_en | output | 1 | Intermediate-level pull-down enable |
| full_off | output | 1 | Full pull-down to the negative rail |
| mid_lvl | output | 3 | One-hot clamp level during the plateau |

## Verification
The bench targets the following corner cases:

- **Programmed counts above the limit.** A missing cap would hold `mid_en` for hundreds of extra cycles.
- **Delays of 0 and 1.** An off-by-one in the counter compare would stretch or shorten both the wait and the plateau.
- **A command that returns high during the plateau.** A design that resumed the old count instead of restarting would turn on early.
- **A command that drops during the turn-on wait.** A design that ignored the drop would issue a runt on-pulse.
- **`plat_cycles` and `lvl_code` changed mid-phase.** A design that did not latch them would bend the running plateau or switch the clamp level during it.
- **The strap.** A design that honoured the strap only for turn-off would leave the turn-on delay in place and distort pulse widths.

// File: rtl/tlto_pkg.sv
package tlto_pkg;

   typedef enum logic [1:0] {
      PH_OFF  = 2'd0,
      PH_WAIT = 2'd1,
      PH_ON   = 2'd2,
      PH_PLAT = 2'd3
   } phase_e;

   // Clamp level code to one-hot select; the unused code maps to the middle level.
   function automatic logic [2:0] lvl_onehot(input logic [1:0] code);
      logic [2:0] sel;
      case (code)
         2'b00:   sel = 3'b001;
         2'b01:   sel = 3'b010;
         2'b10:   sel = 3'b100;
         default: sel = 3'b010;
      endcase
      return sel;
   endfunction

endpackage

// File: rtl/tlto_delay_sel.sv
module tlto_delay_sel #(
   parameter int PLAT_W    = 12,
   parameter int LIMIT_CYC = 500,
   parameter int DW        = 9
) (
   input  logic [PLAT_W-1:0] plat_cycles,
   input  logic              strap_off,
   output logic [DW-1:0]     d_eff
);
   localparam longint MAX_PROG = (longint'(1) << PLAT_W) - 1;

   logic [DW-1:0] d_capped;

   generate
      if (MAX_PROG <= longint'(LIMIT_CYC)) begin : g_nocap
         // Every programmable value is already within the limit.
         assign d_capped = DW'(plat_cycles);
      end else begin : g_cap
         localparam logic [PLAT_W-1:0] LIM_P = PLAT_W'(LIMIT_CYC);
         assign d_capped = (plat_cycles > LIM_P) ? DW'(LIMIT_CYC) : DW'(plat_cycles);
      end
   endgenerate

   assign d_eff = strap_off ? '0 : d_capped;

endmodule

// File: rtl/tlto_phase_cnt.sv
module tlto_phase_cnt #(
   parameter int DW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          step,
   input  logic [DW-1:0] target,
   output logic          done
);
   logic [DW-1:0] cnt_q;
   logic [DW-1:0] tgt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tgt_q <= '0;
      end else if (start) begin
         cnt_q <= DW'(1);
         tgt_q <= target;
      end else if (step) begin
         cnt_q <= cnt_q + DW'(1);
      end
   end

   assign done = (cnt_q == tgt_q);

endmodule

// File: rtl/tlto_lvl_latch.sv
module tlto_lvl_latch
   import tlto_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [1:0] code,
   input  logic       active,
   output logic [2:0] sel
);
   logic [2:0] sel_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    sel_q <= 3'b010;
      else if (load) sel_q <= lvl_onehot(code);
   end

   assign sel = active ? sel_q : 3'b000;

endmodule

// File: rtl/tlto_ctrl.sv
module tlto_ctrl
   import tlto_pkg::*;
#(
   parameter int PLAT_W    = 12,
   parameter int LIMIT_CYC = 500
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_on,
   input  logic [PLAT_W-1:0] plat_cycles,
   input  logic              strap_off,
   input  logic [1:0]        lvl_code,
   output logic              drv_on,
   output logic              mid_en,
   output logic              full_off,
   output logic [2:0]        mid_lvl
);
   localparam int DW = $clog2(LIMIT_CYC + 1);

   initial begin
      assert (LIMIT_CYC >= 1) else $error("LIMIT_CYC must be at least 1");
      assert (PLAT_W >= 1 && PLAT_W <= 32) else $error("PLAT_W out of range");
   end

   phase_e        ph_q, ph_d;
   logic [DW-1:0] d_eff;
   logic          d_zero, start, step, done, load_lvl;

   tlto_delay_sel #(.PLAT_W(PLAT_W), .LIMIT_CYC(LIMIT_CYC), .DW(DW)) u_dsel (
      .plat_cycles (plat_cycles),
      .strap_off   (strap_off),
      .d_eff       (d_eff)
   );

   tlto_phase_cnt #(.DW(DW)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .step   (step),
      .target (d_eff),
      .done   (done)
   );

   tlto_lvl_latch u_lvl (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load_lvl),
      .code   (lvl_code),
      .active (mid_en),
      .sel    (mid_lvl)
   );

   assign d_zero = (d_eff == '0);

   always_comb begin
      ph_d     = ph_q;
      start    = 1'b0;
      step     = 1'b0;
      load_lvl = 1'b0;
      case (ph_q)
         PH_OFF: begin
            if (cmd_on) begin
               if (d_zero) ph_d = PH_ON;
               else begin
                  ph_d  = PH_WAIT;
                  start = 1'b1;
               end
            end
         end
         PH_WAIT: begin
            if (!cmd_on)   ph_d = PH_OFF;
            else if (done) ph_d = PH_ON;
            else           step = 1'b1;
         end
         PH_ON: begin
            if (!cmd_on) begin
               if (d_zero) ph_d = PH_OFF;
               else begin
                  ph_d     = PH_PLAT;
                  start    = 1'b1;
                  load_lvl = 1'b1;
               end
            end
         end
         PH_PLAT: begin
            if (cmd_on) begin
               if (d_zero) ph_d = PH_ON;
               else begin
                  ph_d  = PH_WAIT;
                  start = 1'b1;
               end
            end else if (done) ph_d = PH_OFF;
            else               step = 1'b1;
         end
         default: ph_d = PH_OFF;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ph_q <= PH_OFF;
      else        ph_q <= ph_d;
   end

   assign drv_on   = (ph_q == PH_ON);
   assign mid_en   = (ph_q == PH_PLAT);
   assign full_off = (ph_q == PH_OFF) || (ph_q == PH_WAIT);

endmodule

// File: rtl/tlto_ctrl_chk.sv
module tlto_ctrl_chk #(
   parameter int PLAT_W    = 12,
   parameter int LIMIT_CYC = 500
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_on,
   input logic       strap_off,
   input logic       drv_on,
   input logic       mid_en,
   input logic       full_off,
   input logic [2:0] mid_lvl
);
   localparam int RW = $clog2(LIMIT_CYC + 2);

   logic [RW-1:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                                    run_q <= '0;
      else if (!mid_en)                              run_q <= '0;
      else if (run_q != RW'(LIMIT_CYC + 1))          run_q <= run_q + RW'(1);
   end

   a_r1_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({drv_on, mid_en, full_off}) == 1);

   a_r3_rise_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv_on) |-> $past(cmd_on));

   a_r4_fall_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drv_on) |-> !$past(cmd_on));

   a_r5_plateau_cap: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= RW'(LIMIT_CYC));

   a_r7_strap_no_mid: assert property (@(posedge clk) disable iff (!rst_n)
      strap_off && !mid_en |=> !mid_en);

   a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
      mid_en && cmd_on |=> !mid_en);

   a_r9_lvl_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mid_lvl) && (mid_en == (mid_lvl != 3'b000)));

endmodule

bind tlto_ctrl tlto_ctrl_chk #(.PLAT_W(PLAT_W), .LIMIT_CYC(LIMIT_CYC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_on    (cmd_on),
   .strap_off (strap_off),
   .drv_on    (drv_on),
   .mid_en    (mid_en),
   .full_off  (full_off),
   .mid_lvl   (mid_lvl)
);

// File: tb/sim_tlto_ctrl.sv
`timescale 1ns/1ps
module sim_tlto_ctrl;
   localparam int PW  = 12;
   localparam int LIM = 500;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_on = 1'b0;
   logic [PW-1:0] plat_cycles = '0;
   logic          strap_off = 1'b0;
   logic [1:0]    lvl_code = 2'b00;
   logic          drv_on, mid_en, full_off;
   logic [2:0]    mid_lvl;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   tlto_ctrl #(.PLAT_W(PW), .LIMIT_CYC(LIM)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_on(cmd_on), .plat_cycles(plat_cycles),
      .strap_off(strap_off), .lvl_code(lvl_code), .drv_on(drv_on),
      .mid_en(mid_en), .full_off(full_off), .mid_lvl(mid_lvl));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Effective delay from R2.
   function automatic int eff_delay(input int prog, input bit strap);
      if (strap) return 0;
      return (prog > LIM) ? LIM : prog;
   endfunction

   // Expected one-hot select from R9.
   function automatic logic [2:0] exp_sel(input logic [1:0] c);
      return (c == 2'b00) ? 3'b001 : (c == 2'b10) ? 3'b100 : 3'b010;
   endfunction

   // Reference phase tracker (0 off, 1 wait, 2 on, 3 plateau), built from R2-R10.
   int m_ph = 0, m_t = 0, m_d = 0;
   logic [2:0] m_sel = 3'b000;
   always @(posedge clk) begin
      int de;
      de = eff_delay(int'(plat_cycles), strap_off);
      if (!rst_n) begin
         m_ph = 0; m_t = 0; m_d = 0;
      end else begin
         case (m_ph)
            0: if (cmd_on) begin
                  if (de == 0) m_ph = 2; else begin m_ph = 1; m_t = 1; m_d = de; end
               end
            1: if (!cmd_on) m_ph = 0; else if (m_t >= m_d) m_ph = 2; else m_t++;
            2: if (!cmd_on) begin
                  if (de == 0) m_ph = 0;
                  else begin m_ph = 3; m_t = 1; m_d = de; m_sel = exp_sel(lvl_code); end
               end
            default: if (cmd_on) begin
                  if (de == 0) m_ph = 2; else begin m_ph = 1; m_t = 1; m_d = de; end
               end else if (m_t >= m_d) m_ph = 0; else m_t++;
         endcase
      end
   end

   bit model_on = 0;
   always @(negedge clk) begin
      if (rst_n && model_on && !finished) begin
         chk(drv_on == (m_ph == 2), "R3 drv_on vs model", int'(drv_on), int'(m_ph == 2));
         chk(mid_en == (m_ph == 3), "R4 mid_en vs model", int'(mid_en), int'(m_ph == 3));
         chk(full_off == (m_ph < 2), "R1 full_off vs model", int'(full_off), int'(m_ph < 2));
         chk(mid_lvl == ((m_ph == 3) ? m_sel : 3'b000), "R9 mid_lvl vs model",
             int'(mid_lvl), int'((m_ph == 3) ? m_sel : 3'b000));
      end
   end

   // One full pulse with W sampled-high edges; returns measured intervals in cycles.
   task automatic pulse(input int w, output int rise_lat, output int mid_len,
                        output int rise_to_full, output logic [2:0] sel_seen);
      int idx, i_rise, i_full;
      idx = 0; i_rise = -1; i_full = -1; mid_len = 0; sel_seen = 3'b000;
      cmd_on = 1'b1;
      while (idx < w) begin
         @(negedge clk); idx++;
         if (drv_on && i_rise < 0) i_rise = idx;
      end
      cmd_on = 1'b0;
      for (int k = 0; k < 3000 && i_full < 0; k++) begin
         @(negedge clk); idx++;
         if (drv_on && i_rise < 0) i_rise = idx;
         if (mid_en) begin mid_len++; sel_seen = mid_lvl; end
         if (full_off) i_full = idx;
      end
      rise_lat = i_rise;
      rise_to_full = i_full - i_rise;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      int rl, ml, rf, n;
      logic [2:0] sl;
      void'($urandom(32'd20431));
      repeat (3) @(negedge clk);
      chk(full_off && !drv_on && !mid_en, "R1 reset state", int'({drv_on, mid_en, full_off}), 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(full_off && !drv_on && !mid_en, "R1 idle after reset", int'({drv_on, mid_en, full_off}), 1);
      model_on = 1;

      // Nominal delay of 10, highest clamp level.
      plat_cycles = 12'd10; lvl_code = 2'b10;
      pulse(40, rl, ml, rf, sl);
      chk(rl == 11, "R3 turn-on latency D=10", rl, 11);
      chk(ml == 10, "R4 plateau length D=10", ml, 10);
      chk(rf == 40, "R6 pulse width preserved", rf, 40);
      chk(sl == 3'b100, "R9 code 10 -> bit2", int'(sl), 4);

      // Delay of 1, lowest and unused codes.
      plat_cycles = 12'd1; lvl_code = 2'b00;
      pulse(5, rl, ml, rf, sl);
      chk(rl == 2 && ml == 1, "R4 D=1 latency/plateau", rl * 100 + ml, 201);
      chk(sl == 3'b001, "R9 code 00 -> bit0", int'(sl), 1);
      lvl_code = 2'b11;
      pulse(6, rl, ml, rf, sl);
      chk(sl == 3'b010, "R9 code 11 -> bit1", int'(sl), 2);

      // Programmed above the limit.
      plat_cycles = 12'd900; lvl_code = 2'b01;
      pulse(600, rl, ml, rf, sl);
      chk(ml == LIM, "R5 plateau capped", ml, LIM);
      chk(rl == LIM + 1, "R2 capped turn-on delay", rl, LIM + 1);

      // Strap removes plateau and delay.
      plat_cycles = 12'd50; strap_off = 1'b1;
      pulse(8, rl, ml, rf, sl);
      chk(rl == 1 && ml == 0, "R7 strap no delay/plateau", rl * 100 + ml, 100);
      chk(rf == 8, "R7 strap width", rf, 8);
      strap_off = 1'b0;

      // Zero programmed count behaves like the strap.
      plat_cycles = 12'd0;
      pulse(4, rl, ml, rf, sl);
      chk(rl == 1 && ml == 0, "R2 zero count", rl * 100 + ml, 100);

      // Cancel during the turn-on wait.
      plat_cycles = 12'd20;
      cmd_on = 1'b1; repeat (5) @(negedge clk); cmd_on = 1'b0;
      n = 0;
      for (int k = 0; k < 30; k++) begin @(negedge clk); if (drv_on || mid_en) n++; end
      chk(n == 0, "R3 wait cancel no runt", n, 0);

      // Abort during the plateau restarts the delay from zero.
      cmd_on = 1'b1; repeat (25) @(negedge clk); cmd_on = 1'b0;
      repeat (5) @(negedge clk);
      chk(mid_en == 1'b1, "R8 in plateau", int'(mid_en), 1);
      cmd_on = 1'b1;
      n = 0;
      for (int k = 0; k < 100; k++) begin
         @(negedge clk); n++;
         if (k == 0) chk(!mid_en, "R8 plateau aborted", int'(mid_en), 0);
         if (drv_on) break;
      end
      chk(n == 21, "R8 delay restart", n, 21);
      cmd_on = 1'b0; repeat (25) @(negedge clk);

      // Inputs changed after the plateau has started.
      plat_cycles = 12'd15; lvl_code = 2'b00;
      cmd_on = 1'b1; repeat (20) @(negedge clk); cmd_on = 1'b0;
      @(negedge clk);
      plat_cycles = 12'd3; lvl_code = 2'b10;
      ml = 1;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (mid_en) begin
            ml++;
            if (mid_lvl != 3'b001) chk(0, "R10 level held", int'(mid_lvl), 1);
         end
      end
      chk(ml == 15, "R10 plateau held", ml, 15);

      // Constrained random mix.
      for (int it = 0; it < 300; it++) begin
         int r;
         r = $urandom_range(0, 9);
         if (r == 0) plat_cycles = PW'($urandom_range(490, 520));
         else if (r < 3) plat_cycles = PW'($urandom_range(0, 2));
         else plat_cycles = PW'($urandom_range(0, 40));
         strap_off = ($urandom_range(0, 9) == 0);
         lvl_code = 2'($urandom_range(0, 3));
         cmd_on = ~cmd_on;
         repeat ($urandom_range(1, 45)) @(negedge clk);
      end
      cmd_on = 1'b0;
      repeat (600) @(negedge clk);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; failures++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule